// File: doc/BRIEF.md
# Helicity Reporting Delay Line

This block hides the real-time beam helicity from downstream consumers. It keeps a history of the helicity of past windows and reports the helicity from a selectable number of windows earlier. The history advances once per helicity window, not once per clock. The timing generator raises a one-cycle window strobe at each window boundary and presents the helicity of the new window on the same cycle. The block updates its reported value one clock after that strobe, together with the other window-aligned outputs.

The delay is chosen with a 4-bit code. The code maps onto a fixed, non-uniform set of depths up to 128 windows. The code is sampled only at window boundaries. A valid flag tells consumers when the reported value comes from windows that were recorded under the current code. The flag drops after reset and after any change of code, and it rises once enough windows have been recorded.

Top module: `heli_window_delay`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, `helOut` is 0 and `helValid` is 0.
- R2: The delay code maps to a depth in windows as follows: 0→0, 1→1, 2→2, 3→4, 4→8, 5→12, 6→16, 7→24, 8→32, 9→40, 10→48, 11→64, 12→72, 13→96, 14→112, 15→128.
- R3: For a depth n > 0, after the clock edge that samples a strobe, `helOut` equals the `helIn` that was sampled at the strobe n strobes before this one. If fewer than n strobes have occurred since reset, `helOut` is 0.
- R4: With code 0, `helOut` after a strobe equals the `helIn` sampled at that same strobe.
- R5: `helOut` and `helValid` change only on the clock edge that samples a strobe. Between strobes they hold, whatever `helIn` and `delayCode` do.
- R6: After a strobe, `helValid` is 1 exactly when the count of strobes since reset or since the last code change, including this strobe, is greater than the depth n.
- R7: `delayCode` is sampled only at strobes. A code that differs from the one sampled at the previous strobe takes effect at that strobe and restarts the count used by R6 at 1.
- R8: The history holds 128 windows, so code 15 reports the helicity from 128 windows earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| winStrobe | input | 1 | One-cycle pulse at each helicity window boundary |
| helIn | input | 1 | Helicity of the window that starts at the strobe |
| delayCode | input | 4 | Reporting delay selection code |
| helOut | output | 1 | Delayed helicity |
| helValid | output | 1 | Delayed helicity comes from a fully recorded history under the current code |

## Verification
The bench goes after the edges of the depth table:
- Code 0 must pass the current window straight through. An off-by-one tap would report the previous window instead.
- Code 15 must reach the oldest stage. A history one stage short would show errors only after 128 windows.

The bench changes the code at strobes and checks that the valid flag restarts. A design that kept counting through a change would raise the flag too early. The bench also changes the code and the helicity between strobes and checks that the outputs hold. A design that decoded the code combinationally, or shifted every clock, would move the output mid-window. Back-to-back strobes check that each strobe advances the history exactly once.

// File: rtl/heli_delay_pkg.sv
package heli_delay_pkg;
  localparam int MAX_DEPTH = 128;
  localparam int CODE_W    = 4;
  localparam int TAP_W     = $clog2(MAX_DEPTH + 2);
  localparam int IDX_W     = $clog2(MAX_DEPTH);

  typedef struct packed {
    logic             shift;
    logic [TAP_W-1:0] tap;
    logic             ready;
  } ctlStrobe_t;

  // R2 code to depth in windows
  function automatic logic [TAP_W-1:0] depthOf(input logic [CODE_W-1:0] code);
    int d;
    case (code)
      4'd0:  d = 0;
      4'd1:  d = 1;
      4'd2:  d = 2;
      4'd3:  d = 4;
      4'd4:  d = 8;
      4'd5:  d = 12;
      4'd6:  d = 16;
      4'd7:  d = 24;
      4'd8:  d = 32;
      4'd9:  d = 40;
      4'd10: d = 48;
      4'd11: d = 64;
      4'd12: d = 72;
      4'd13: d = 96;
      4'd14: d = 112;
      default: d = 128;
    endcase
    if (d > MAX_DEPTH) d = MAX_DEPTH;
    return TAP_W'(d);
  endfunction
endpackage

// File: rtl/heli_delay_ctl.sv
module heli_delay_ctl
  import heli_delay_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              winStrobe,
  input  logic [CODE_W-1:0] delayCode,
  output ctlStrobe_t        ctl
);
  localparam logic [TAP_W-1:0] CNT_SAT = TAP_W'(MAX_DEPTH + 1);

  logic [CODE_W-1:0] activeCode;
  logic [TAP_W-1:0]  fillCnt;
  logic [TAP_W-1:0]  nextCnt;
  logic [TAP_W-1:0]  depth;
  logic              codeChanged;

  always_comb begin
    depth       = depthOf(delayCode);
    codeChanged = (delayCode != activeCode);
    if (codeChanged)
      nextCnt = TAP_W'(1);
    else if (fillCnt >= CNT_SAT)
      nextCnt = CNT_SAT;
    else
      nextCnt = fillCnt + TAP_W'(1);
    ctl.shift = winStrobe;
    ctl.tap   = depth;
    ctl.ready = (nextCnt > depth);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= '0;
      fillCnt    <= '0;
    end else if (winStrobe) begin
      activeCode <= delayCode;
      fillCnt    <= nextCnt;
    end
  end
endmodule

// File: rtl/heli_delay_path.sv
module heli_delay_path
  import heli_delay_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic       helIn,
  output logic       helOut,
  output logic       helValid
);
  logic [MAX_DEPTH-1:0] hist;
  logic [IDX_W-1:0]     tapIdx;
  logic                 tapBit;

  assign tapIdx = IDX_W'(ctl.tap - TAP_W'(1));
  assign tapBit = (ctl.tap == '0) ? helIn : hist[tapIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= '0;
      helOut   <= 1'b0;
      helValid <= 1'b0;
    end else if (ctl.shift) begin
      hist     <= {hist[MAX_DEPTH-2:0], helIn};
      helOut   <= tapBit;
      helValid <= ctl.ready;
    end
  end
endmodule

// File: rtl/heli_window_delay.sv
module heli_window_delay
  import heli_delay_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              winStrobe,
  input  logic              helIn,
  input  logic [CODE_W-1:0] delayCode,
  output logic              helOut,
  output logic              helValid
);
  ctlStrobe_t ctl;

  heli_delay_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .winStrobe (winStrobe),
    .delayCode (delayCode),
    .ctl       (ctl)
  );

  heli_delay_path uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .helIn    (helIn),
    .helOut   (helOut),
    .helValid (helValid)
  );
endmodule

// File: rtl/heli_delay_chk.sv
module heli_delay_chk
  import heli_delay_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              winStrobe,
  input logic              helIn,
  input logic [CODE_W-1:0] delayCode,
  input logic              helOut,
  input logic              helValid
);
  logic [CODE_W-1:0] lastCode;
  logic              lastHel;
  logic              seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCode <= '0;
      lastHel  <= 1'b0;
      seen     <= 1'b0;
    end else if (winStrobe) begin
      lastCode <= delayCode;
      lastHel  <= helIn;
      seen     <= 1'b1;
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !winStrobe |=> ($stable(helOut) && $stable(helValid))); // R5

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (winStrobe && delayCode == '0) |=> (helOut == $past(helIn) && helValid)); // R4

  AST_ONE_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (winStrobe && delayCode == CODE_W'(1) && seen) |=> (helOut == $past(lastHel))); // R3

  AST_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (winStrobe && delayCode != lastCode && delayCode != '0) |=> !helValid); // R7

  AST_VALID_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(helValid) |-> $past(winStrobe)); // R6
endmodule

bind heli_window_delay heli_delay_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .winStrobe (winStrobe),
  .helIn     (helIn),
  .delayCode (delayCode),
  .helOut    (helOut),
  .helValid  (helValid)
);

// File: tb/tb_heli_window_delay.sv
module tb_heli_window_delay;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       winStrobe = 1'b0;
  logic       helIn = 1'b0;
  logic [3:0] delayCode = 4'd0;
  logic       helOut;
  logic       helValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic mh [0:8191];
  int   total = 0;
  int   fill = 0;
  int   lastCode = 0;
  logic expHel = 1'b0;
  logic expVal = 1'b0;

  always #5 clk = ~clk;

  heli_window_delay dut (
    .clk(clk), .rstN(rstN), .winStrobe(winStrobe), .helIn(helIn),
    .delayCode(delayCode), .helOut(helOut), .helValid(helValid)
  );

  function automatic int refDepth(input int c);
    case (c)
      0: return 0;   1: return 1;   2: return 2;   3: return 4;
      4: return 8;   5: return 12;  6: return 16;  7: return 24;
      8: return 32;  9: return 40;  10: return 48; 11: return 64;
      12: return 72; 13: return 96; 14: return 112;
      default: return 128;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at t=%0t", tag, act, exp, $time);
    end
  endtask

  // at a negedge on entry; leaves strobe high, caller drops it
  task automatic strobe(input logic h, input int c);
    int n;
    bit changed;
    helIn = h;
    delayCode = 4'(c);
    winStrobe = 1'b1;
    @(negedge clk);
    n = refDepth(c);
    changed = (c != lastCode);
    mh[total] = h;
    total++;
    if (changed) fill = 1;
    else if (fill < 129) fill++;
    lastCode = c;
    expHel = (n == 0) ? h : ((total > n) ? mh[total-1-n] : 1'b0);
    expVal = (fill > n);
    if (c == 15)      check("R8 R2 helOut depth 128", helOut, expHel);
    else if (n == 0)  check("R4 helOut passthrough", helOut, expHel);
    else              check($sformatf("R3 R2 helOut code %0d", c), helOut, expHel);
    if (changed) check("R7 helValid after code change", helValid, expVal);
    else         check("R6 helValid", helValid, expVal);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      winStrobe = 1'b0;
      helIn = 1'($urandom);
      delayCode = 4'($urandom);
      @(negedge clk);
      check("R5 helOut holds", helOut, expHel);
      check("R5 helValid holds", helValid, expVal);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 helOut in reset", helOut, 1'b0);
    check("R1 helValid in reset", helValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    idle(3);
    check("R1 helValid after reset", helValid, 1'b0);

    // code 0 passthrough, back to back strobes
    for (int i = 0; i < 6; i++) strobe(1'(i % 3 == 0), 0);
    idle(1);
    // code 1 and 2, then change and restart
    for (int i = 0; i < 5; i++) begin strobe(1'($urandom), 1); idle(1); end
    for (int i = 0; i < 6; i++) begin strobe(1'($urandom), 3); idle(2); end
    for (int i = 0; i < 3; i++) strobe(1'($urandom), 2);
    idle(1);
    // deepest code, long run past 128
    for (int i = 0; i < 140; i++) begin strobe(1'($urandom), 15); idle(i % 2); end
    // change away from 15 and back
    strobe(1'b1, 14);
    idle(1);
    for (int i = 0; i < 130; i++) strobe(1'($urandom), 15);
    idle(2);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int c = int'($urandom_range(0, 15));
      int len = int'($urandom_range(1, 150));
      for (int i = 0; i < len; i++) begin
        int cc = ($urandom_range(0, 19) == 0) ? int'($urandom_range(0, 15)) : c;
        strobe(1'($urandom), cc);
        idle(int'($urandom_range(0, 3)));
      end
    end
    winStrobe = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule